// File: doc/BRIEF.md
# Text RAM Write-Permission Gate

This block sits between a CPU write path and the text/attribute memory of a character display. Every CPU byte or word write that falls into the text window is classified by address sub-range and address parity, and the gate decides in the same cycle whether each byte goes to character RAM, to the attribute area, to a small character-generator font RAM, or nowhere. Accepted text writes produce a RAM strobe with byte-lane enables and a dirty pulse per touched display cell. Accepted font writes produce a font RAM strobe with an index formed from a programmable base.

A small control port loads a font-control register (bit 0 = font window writable, bit 7 = "font written" latch) and the font base, and clears a sticky "text changed" flag. The address window is split into five classes held in an enumerated region type: `RG_NONE` (outside the window), `RG_FREE`, `RG_EVEN`, `RG_GUARD` and `RG_FONT`. The block has no sequencing state; the region class plays the role of the state and is selected with a `unique case`.

Top module: `txg_write_gate`

## Requirements
- R1: A write with address in 0xA0000..0xA1FFF always lands: a byte write gives `ram_be`=01 at `ram_addr`=address with the byte on `ram_data[7:0]`; a word write gives `ram_be`=11, low byte on lane 0 at the address and high byte on lane 1 at address+1, for either parity.
- R2: In 0xA2000..0xA3FDF an even-address byte write lands (`ram_be`=01) and an odd-address byte write is dropped (`ram_be`=00).
- R3: In 0xA2000..0xA3FFF a word write to an odd address lands only its high byte, on lane 0 at address+1; a word write to an even address lands only its low byte at the address.
- R4: In 0xA3FE0..0xA3FFF an even byte (after the R3 adjustment for words) lands only if its address bit 1 is 0 or `sw_access_en`=1; odd byte writes are dropped.
- R5: In 0xA4000..0xA4FFF only odd-address byte writes are accepted, and only while bit 0 of `cg_ctrl` is 1; an accepted write pulses `font_we` with `font_idx` = font base + address[4:1] (modulo 256) and `font_data` = the byte. Text RAM strobes stay 0 there.
- R6: In the font window a word write to an even address delivers its high data byte to font RAM, a word write to an odd address delivers its low byte, both gated by `cg_ctrl` bit 0.
- R7: Each accepted font write sets bit 7 of `cg_ctrl` at the next clock edge, also when a control write to selector 0 happens in the same cycle.
- R8: For every landed RAM lane, `dirty_we` has the same bit set; lane 0 reports cell (lane address >> 1) mod 4096 on `dirty_cell0`, lane 1 reports ((address+1) >> 1) mod 4096 on `dirty_cell1`.
- R9: `text_changed` becomes 1 at the clock edge after any landed RAM write, stays set, and is cleared by a control write with selector 2; a landed write in the same cycle wins over the clear.
- R10: With `wr_en`=0, for addresses below 0xA0000 or at/above 0xA5000, and for every rejected write, `ram_be`, `dirty_we` and `font_we` are all 0 in that cycle; all decisions are combinational in the request cycle.
- R11: After reset `cg_ctrl`=0, the font base is 0 and `text_changed`=0.
- R12: A control write with selector 0 loads `cg_ctrl` from `ctrl_wdata`; selector 1 loads the font base; selector 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write request this cycle |
| wr_word | input | 1 | 1 = word write, 0 = byte write |
| wr_addr | input | 20 | CPU byte address |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| sw_access_en | input | 1 | Opens the guarded top-of-attribute bytes |
| ctrl_we | input | 1 | Control register write |
| ctrl_sel | input | 2 | 0 font control, 1 font base, 2 clear text flag, 3 none |
| ctrl_wdata | input | 8 | Control write data |
| ram_be | output | 2 | Lane enables: bit 0 at ram_addr, bit 1 at ram_addr+1 |
| ram_addr | output | 20 | Byte address of lane 0 |
| ram_data | output | 16 | Lane 0 data in 7:0, lane 1 data in 15:8 |
| font_we | output | 1 | Font RAM write strobe |
| font_idx | output | 8 | Font RAM index |
| font_data | output | 8 | Font RAM write byte |
| dirty_we | output | 2 | Dirty pulse per landed lane |
| dirty_cell0 | output | 12 | Cell index for lane 0 |
| dirty_cell1 | output | 12 | Cell index for lane 1 |
| text_changed | output | 1 | Sticky text-written flag |
| cg_ctrl | output | 8 | Font control register (bit 0 writable, bit 7 written) |

## Verification
The assertions take for granted that `wr_en`, `ctrl_we` and their companions are stable, known values around each rising edge and that only one CPU request is presented per cycle. The stimulus respects this by changing every input on the falling edge and holding it through the next rising edge. Word writes are kept away from region boundaries where lane 1 would spill into the next sub-range, since the gate classifies a request only by its start address.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_FREE  = 3'd1,
        RG_EVEN  = 3'd2,
        RG_GUARD = 3'd3,
        RG_FONT  = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        CS_FLAGS = 2'd0,
        CS_BASE  = 2'd1,
        CS_CLEAR = 2'd2,
        CS_IDLE  = 2'd3
    } ctrl_sel_e;

    localparam int FLAG_WRITABLE_BIT = 0;
    localparam int FLAG_WRITTEN_BIT  = 7;

endpackage

// File: rtl/txg_region_decode.sv
module txg_region_decode
    import txg_pkg::*;
#(
    parameter int              ADDR_W   = 20,
    parameter logic [ADDR_W-1:0] WIN_LO   = 20'hA0000,
    parameter logic [ADDR_W-1:0] EVEN_LO  = 20'hA2000,
    parameter logic [ADDR_W-1:0] GUARD_LO = 20'hA3FE0,
    parameter logic [ADDR_W-1:0] FONT_LO  = 20'hA4000,
    parameter logic [ADDR_W-1:0] WIN_HI   = 20'hA5000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    always_comb begin
        if (addr < WIN_LO || addr >= WIN_HI) begin
            region = RG_NONE;
        end else if (addr < EVEN_LO) begin
            region = RG_FREE;
        end else if (addr < GUARD_LO) begin
            region = RG_EVEN;
        end else if (addr < FONT_LO) begin
            region = RG_GUARD;
        end else begin
            region = RG_FONT;
        end
    end

endmodule

// File: rtl/txg_lane_select.sv
module txg_lane_select
    import txg_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CTRL_W = 8
) (
    input  logic              req,
    input  region_e           region,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data,
    input  logic              word,
    input  logic              sw_en,
    input  logic              font_open,
    input  logic [CTRL_W-1:0] font_base,
    output logic [1:0]        be,
    output logic [ADDR_W-1:0] lane_addr,
    output logic [15:0]       lane_data,
    output logic              font_we,
    output logic [CTRL_W-1:0] font_idx,
    output logic [7:0]        font_data
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] even_addr;
    logic [7:0]        even_byte;
    logic              even_ok;
    logic [CTRL_W-1:0] slot;

    // Word to odd address shifts onto the next even byte with the high half.
    always_comb begin
        if (word && addr[0]) begin
            even_addr = addr + ONE;
            even_byte = data[15:8];
            even_ok   = 1'b1;
        end else begin
            even_addr = addr;
            even_byte = data[7:0];
            even_ok   = !addr[0];
        end
    end

    assign slot = CTRL_W'(addr[4:1]);

    always_comb begin
        be        = 2'b00;
        lane_addr = '0;
        lane_data = '0;
        font_we   = 1'b0;
        font_idx  = '0;
        font_data = '0;
        if (req) begin
            unique case (region)
                RG_FREE: begin
                    be        = word ? 2'b11 : 2'b01;
                    lane_addr = addr;
                    lane_data = word ? data : {8'h00, data[7:0]};
                end
                RG_EVEN: begin
                    if (even_ok) begin
                        be        = 2'b01;
                        lane_addr = even_addr;
                        lane_data = {8'h00, even_byte};
                    end
                end
                RG_GUARD: begin
                    if (even_ok && (!even_addr[1] || sw_en)) begin
                        be        = 2'b01;
                        lane_addr = even_addr;
                        lane_data = {8'h00, even_byte};
                    end
                end
                RG_FONT: begin
                    if (font_open && (word || addr[0])) begin
                        font_we   = 1'b1;
                        font_idx  = font_base + slot;
                        font_data = (word && !addr[0]) ? data[15:8] : data[7:0];
                    end
                end
                RG_NONE: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/txg_ctrl_regs.sv
module txg_ctrl_regs
    import txg_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [1:0]        ctrl_sel,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              font_hit,
    input  logic              text_hit,
    output logic [CTRL_W-1:0] cg_ctrl,
    output logic [CTRL_W-1:0] font_base,
    output logic              text_changed
);

    ctrl_sel_e         sel;
    logic [CTRL_W-1:0] flags_next;
    logic [CTRL_W-1:0] written_mask;

    assign sel          = ctrl_sel_e'(ctrl_sel);
    assign written_mask = CTRL_W'(1) << FLAG_WRITTEN_BIT;

    always_comb begin
        flags_next = cg_ctrl;
        if (ctrl_we && sel == CS_FLAGS) begin
            flags_next = ctrl_wdata;
        end
        if (font_hit) begin
            flags_next = flags_next | written_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cg_ctrl      <= '0;
            font_base    <= '0;
            text_changed <= 1'b0;
        end else begin
            cg_ctrl <= flags_next;
            if (ctrl_we && sel == CS_BASE) begin
                font_base <= ctrl_wdata;
            end
            if (text_hit) begin
                text_changed <= 1'b1;
            end else if (ctrl_we && sel == CS_CLEAR) begin
                text_changed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/txg_write_gate.sv
module txg_write_gate
    import txg_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CTRL_W = 8,
    parameter int CELL_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              sw_access_en,
    input  logic              ctrl_we,
    input  logic [1:0]        ctrl_sel,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [1:0]        ram_be,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [15:0]       ram_data,
    output logic              font_we,
    output logic [CTRL_W-1:0] font_idx,
    output logic [7:0]        font_data,
    output logic [1:0]        dirty_we,
    output logic [CELL_W-1:0] dirty_cell0,
    output logic [CELL_W-1:0] dirty_cell1,
    output logic              text_changed,
    output logic [CTRL_W-1:0] cg_ctrl
);

    region_e           region;
    logic [CTRL_W-1:0] font_base;

    txg_region_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (wr_addr),
        .region (region)
    );

    txg_lane_select #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_lanes (
        .req       (wr_en),
        .region    (region),
        .addr      (wr_addr),
        .data      (wr_data),
        .word      (wr_word),
        .sw_en     (sw_access_en),
        .font_open (cg_ctrl[FLAG_WRITABLE_BIT]),
        .font_base (font_base),
        .be        (ram_be),
        .lane_addr (ram_addr),
        .lane_data (ram_data),
        .font_we   (font_we),
        .font_idx  (font_idx),
        .font_data (font_data)
    );

    txg_ctrl_regs #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_sel     (ctrl_sel),
        .ctrl_wdata   (ctrl_wdata),
        .font_hit     (font_we),
        .text_hit     (|ram_be),
        .cg_ctrl      (cg_ctrl),
        .font_base    (font_base),
        .text_changed (text_changed)
    );

    // Cell of address+1 is the lane-0 cell plus the lane-0 address parity.
    assign dirty_we    = ram_be;
    assign dirty_cell0 = ram_addr[CELL_W:1];
    assign dirty_cell1 = ram_addr[CELL_W:1] + CELL_W'(ram_addr[0]);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (ram_be == 2'b00 && !font_we && dirty_we == 2'b00));

    // R10
    font_text_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(font_we && (|ram_be)));

    // R5
    font_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        font_we |-> cg_ctrl[FLAG_WRITABLE_BIT]);

    // R7
    font_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        font_we |=> cg_ctrl[FLAG_WRITTEN_BIT]);

    // R9
    text_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ram_be) |=> text_changed);

    // R2
    even_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_word && wr_addr[0] && wr_addr >= 20'hA2000 && wr_addr < 20'hA4000)
        |-> ram_be == 2'b00);

    // R10
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr < 20'hA0000 || wr_addr >= 20'hA5000) |-> (ram_be == 2'b00 && !font_we));

endmodule

// File: tb/txg_write_gate_tb.sv
module txg_write_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sw_access_en = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [1:0]  ctrl_sel = 2'd3;
    logic [7:0]  ctrl_wdata = '0;
    logic [1:0]  ram_be;
    logic [19:0] ram_addr;
    logic [15:0] ram_data;
    logic        font_we;
    logic [7:0]  font_idx;
    logic [7:0]  font_data;
    logic [1:0]  dirty_we;
    logic [11:0] dirty_cell0;
    logic [11:0] dirty_cell1;
    logic        text_changed;
    logic [7:0]  cg_ctrl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    txg_write_gate u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_addr(wr_addr), .wr_data(wr_data), .sw_access_en(sw_access_en),
        .ctrl_we(ctrl_we), .ctrl_sel(ctrl_sel), .ctrl_wdata(ctrl_wdata),
        .ram_be(ram_be), .ram_addr(ram_addr), .ram_data(ram_data),
        .font_we(font_we), .font_idx(font_idx), .font_data(font_data),
        .dirty_we(dirty_we), .dirty_cell0(dirty_cell0), .dirty_cell1(dirty_cell1),
        .text_changed(text_changed), .cg_ctrl(cg_ctrl)
    );

    typedef struct packed {
        logic        w;
        logic [19:0] a;
        logic [15:0] d;
        logic        sw;
        logic [1:0]  ebe;
        logic [19:0] ea;
        logic [15:0] ed;
        logic        ef;
        logic [7:0]  efi;
        logic [7:0]  efd;
    } vec_t;

    // Table assumes cg_ctrl = 0x01 and font base = 0x20.
    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 20'hA0010, 16'h00AB, 1'b0, 2'b01, 20'hA0010, 16'h00AB, 1'b0, 8'h00, 8'h00}, // R1
        '{1'b0, 20'hA0011, 16'h0034, 1'b0, 2'b01, 20'hA0011, 16'h0034, 1'b0, 8'h00, 8'h00}, // R1
        '{1'b1, 20'hA1001, 16'hBEEF, 1'b0, 2'b11, 20'hA1001, 16'hBEEF, 1'b0, 8'h00, 8'h00}, // R1 R8
        '{1'b1, 20'hA0100, 16'h1357, 1'b0, 2'b11, 20'hA0100, 16'h1357, 1'b0, 8'h00, 8'h00}, // R1 R8
        '{1'b0, 20'hA2000, 16'h0055, 1'b0, 2'b01, 20'hA2000, 16'h0055, 1'b0, 8'h00, 8'h00}, // R2
        '{1'b0, 20'hA2001, 16'h0066, 1'b0, 2'b00, 20'h00000, 16'h0000, 1'b0, 8'h00, 8'h00}, // R2
        '{1'b1, 20'hA3001, 16'h1234, 1'b0, 2'b01, 20'hA3002, 16'h0012, 1'b0, 8'h00, 8'h00}, // R3
        '{1'b1, 20'hA3004, 16'h5678, 1'b0, 2'b01, 20'hA3004, 16'h0078, 1'b0, 8'h00, 8'h00}, // R3
        '{1'b0, 20'hA3FE0, 16'h0011, 1'b0, 2'b01, 20'hA3FE0, 16'h0011, 1'b0, 8'h00, 8'h00}, // R4
        '{1'b0, 20'hA3FE2, 16'h0022, 1'b0, 2'b00, 20'h00000, 16'h0000, 1'b0, 8'h00, 8'h00}, // R4
        '{1'b0, 20'hA3FE2, 16'h0022, 1'b1, 2'b01, 20'hA3FE2, 16'h0022, 1'b0, 8'h00, 8'h00}, // R4
        '{1'b1, 20'hA3FE1, 16'hAABB, 1'b0, 2'b00, 20'h00000, 16'h0000, 1'b0, 8'h00, 8'h00}, // R4 R3
        '{1'b1, 20'hA3FE5, 16'hAABB, 1'b0, 2'b01, 20'hA3FE6, 16'h00AA, 1'b0, 8'h00, 8'h00}, // R4 R3 (bit1 set, opened below)
        '{1'b0, 20'hA3FE1, 16'h0033, 1'b1, 2'b00, 20'h00000, 16'h0000, 1'b0, 8'h00, 8'h00}, // R4
        '{1'b0, 20'hA4003, 16'h0077, 1'b0, 2'b00, 20'h00000, 16'h0000, 1'b1, 8'h21, 8'h77}, // R5
        '{1'b0, 20'hA4002, 16'h0088, 1'b0, 2'b00, 20'h00000, 16'h0000, 1'b0, 8'h00, 8'h00}, // R5
        '{1'b1, 20'hA401E, 16'h9A5C, 1'b0, 2'b00, 20'h00000, 16'h0000, 1'b1, 8'h2F, 8'h9A}, // R6
        '{1'b1, 20'hA4005, 16'h9A5C, 1'b0, 2'b00, 20'h00000, 16'h0000, 1'b1, 8'h22, 8'h5C}, // R6
        '{1'b0, 20'hA5000, 16'h0099, 1'b1, 2'b00, 20'h00000, 16'h0000, 1'b0, 8'h00, 8'h00}  // R10
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        wr_en   = 1'b0;
        ctrl_we = 1'b0;
        ctrl_sel = 2'd3;
    endtask

    task automatic ctrl_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en      = 1'b0;
        ctrl_we    = 1'b1;
        ctrl_sel   = sel;
        ctrl_wdata = val;
        @(negedge clk);
        ctrl_we  = 1'b0;
        ctrl_sel = 2'd3;
    endtask

    task automatic cpu_write(input logic w, input logic [19:0] a, input logic [15:0] d, input logic sw);
        @(negedge clk);
        ctrl_we      = 1'b0;
        wr_en        = 1'b1;
        wr_word      = w;
        wr_addr      = a;
        wr_data      = d;
        sw_access_en = sw;
        #2;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] nxt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cg_ctrl == 8'h00, "R11 cg_ctrl", 32'(cg_ctrl), 32'h0);
        chk(text_changed == 1'b0, "R11 text_changed", 32'(text_changed), 32'h0);

        // R5: font window closed after reset
        cpu_write(1'b0, 20'hA4003, 16'h0044, 1'b0);
        chk(font_we == 1'b0, "R5 closed window", 32'(font_we), 32'h0);

        // R10: no request, no strobe
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 20'hA0000; #2;
        chk(ram_be == 2'b00 && !font_we && dirty_we == 2'b00, "R10 idle", 32'(ram_be), 32'h0);
        chk(text_changed == 1'b0, "R9 no text yet", 32'(text_changed), 32'h0);

        // R12 load control and base
        ctrl_write(2'd0, 8'h01);
        ctrl_write(2'd1, 8'h20);
        ctrl_write(2'd3, 8'hFF);
        chk(cg_ctrl == 8'h01, "R12 flags load", 32'(cg_ctrl), 32'h01);

        for (int i = 0; i < NV; i++) begin
            cpu_write(TBL[i].w, TBL[i].a, TBL[i].d, TBL[i].sw | (TBL[i].a == 20'hA3FE5));
            chk(ram_be == TBL[i].ebe, $sformatf("vec%0d ram_be", i), 32'(ram_be), 32'(TBL[i].ebe));
            chk(dirty_we == TBL[i].ebe, $sformatf("R8 vec%0d dirty_we", i), 32'(dirty_we), 32'(TBL[i].ebe));
            if (TBL[i].ebe[0]) begin
                chk(ram_addr == TBL[i].ea, $sformatf("vec%0d ram_addr", i), 32'(ram_addr), 32'(TBL[i].ea));
                chk(ram_data[7:0] == TBL[i].ed[7:0], $sformatf("vec%0d lane0", i), 32'(ram_data[7:0]), 32'(TBL[i].ed[7:0]));
                chk(dirty_cell0 == TBL[i].ea[12:1], $sformatf("R8 vec%0d cell0", i), 32'(dirty_cell0), 32'(TBL[i].ea[12:1]));
            end
            if (TBL[i].ebe[1]) begin
                nxt = TBL[i].ea + 20'd1;
                chk(ram_data[15:8] == TBL[i].ed[15:8], $sformatf("vec%0d lane1", i), 32'(ram_data[15:8]), 32'(TBL[i].ed[15:8]));
                chk(dirty_cell1 == nxt[12:1], $sformatf("R8 vec%0d cell1", i), 32'(dirty_cell1), 32'(nxt[12:1]));
            end
            chk(font_we == TBL[i].ef, $sformatf("vec%0d font_we", i), 32'(font_we), 32'(TBL[i].ef));
            if (TBL[i].ef) begin
                chk(font_idx == TBL[i].efi, $sformatf("vec%0d font_idx", i), 32'(font_idx), 32'(TBL[i].efi));
                chk(font_data == TBL[i].efd, $sformatf("vec%0d font_data", i), 32'(font_data), 32'(TBL[i].efd));
            end
        end
        idle_cycle();
        #2;
        // R7 written latch, R9 sticky flag
        chk(cg_ctrl == 8'h81, "R7 written latch", 32'(cg_ctrl), 32'h81);
        chk(text_changed == 1'b1, "R9 set", 32'(text_changed), 32'h1);

        // R10 below window
        cpu_write(1'b1, 20'h9FFFE, 16'h1111, 1'b1);
        chk(ram_be == 2'b00 && !font_we, "R10 below window", 32'(ram_be), 32'h0);

        // R9 clear
        ctrl_write(2'd2, 8'h00);
        chk(text_changed == 1'b0, "R9 clear", 32'(text_changed), 32'h0);

        // R9 set wins over clear in the same cycle
        cpu_write(1'b0, 20'hA0020, 16'h0001, 1'b0);
        ctrl_we = 1'b1; ctrl_sel = 2'd2;
        idle_cycle();
        #2;
        chk(text_changed == 1'b1, "R9 set beats clear", 32'(text_changed), 32'h1);

        // R7 font write wins bit 7 over a same-cycle flags load
        ctrl_write(2'd0, 8'h01);
        cpu_write(1'b0, 20'hA4001, 16'h00C3, 1'b0);
        ctrl_we = 1'b1; ctrl_sel = 2'd0; ctrl_wdata = 8'h01;
        idle_cycle();
        #2;
        chk(cg_ctrl == 8'h81, "R7 latch with load", 32'(cg_ctrl), 32'h81);

        // R12 new base, font index wraps modulo 256
        ctrl_write(2'd1, 8'hFE);
        cpu_write(1'b0, 20'hA4007, 16'h005A, 1'b0);
        chk(font_idx == 8'h01, "R12 R5 base wrap", 32'(font_idx), 32'h01);

        // R5 window closed again by clearing bit 0
        ctrl_write(2'd0, 8'h00);
        cpu_write(1'b1, 20'hA4000, 16'h1234, 1'b0);
        chk(font_we == 1'b0, "R6 closed window word", 32'(font_we), 32'h0);
        idle_cycle();
        #2;
        chk(cg_ctrl == 8'h00, "R12 flags cleared", 32'(cg_ctrl), 32'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule